// File: doc/BRIEF.md
# Floating-Point Condition Evaluator with Debug Halt

This block decides whether a floating-point condition holds, using the result flags of the last operation (negative, zero, infinity, not-a-number) together with the accumulated exception bits. When an instruction carrying a condition is presented while the core is running and the condition holds, the block asserts a halt that stays up until a resume pulse arrives. When the condition does not hold, the instruction simply retires and execution continues.

The condition set follows IEEE comparison semantics. Some conditions treat a NaN operand as a legal outcome: equality, sign tests, ordered/unordered and the error test. The others are ordered comparisons and infinity tests, which do not expect a NaN. When one of these is evaluated and the NaN flag is set, the block sets two sticky flags: an unordered-compare flag and an invalid-operation flag. The sticky flags are only ever set by evaluation. A separate synchronous clear port with a per-bit mask clears them. The block never alters the status flags it reads.

Top module: `fcond_trap`

## Requirements
- R1: After a synchronous active-low reset, `halt`, `unord_sticky` and `inval_sticky` are 0.
- R2: `cond_true` is combinational in `cond_sel`. The codes are: 0 (equal) is Z; 10 (not equal) is !Z; 9 (minus) is N; 19 (plus) is !N; 18 (ordered) is !NAN; 20 (unordered) is NAN.
- R3: The ordered comparisons are computed as follows: 5 (greater) is !(NAN|Z|N); 2 (greater-or-equal) is !(NAN|(N&!Z)); 8 (less) is !(NAN|Z|!N); 7 (less-or-equal) is !(NAN|!(N|Z)); 3 (greater-or-less) is !(NAN|Z); 4 (comparable) is !NAN.
- R4: Codes 14, 11, 17, 16, 12 and 13 are the inverses of codes 5, 2, 8, 7, 3 and 4 respectively.
- R5: Code 6 (infinity) is I and code 15 (not infinity) is !I.
- R6: Code 1 (error) is true when `unord_sticky` or any bit of `exc_in` is set. The `exc_in` bits are: bit 0 signalling NaN, bit 1 operand error, bit 2 overflow, bit 3 underflow, bit 4 divide by zero.
- R7: Codes 21 to 31 give `cond_true`=0. An accepted strobe with such a code causes no halt and sets no sticky flag.
- R8: A strobe is accepted when `instr_valid`=1 and `halt`=0. An accepted strobe with a code from {2,3,4,5,6,7,8,11,12,13,14,15,16,17} and NAN=1 sets both sticky flags at the next clock edge.
- R9: An accepted strobe with a code from {0,1,9,10,18,19,20} never sets either sticky flag.
- R10: An accepted strobe whose condition is true raises `halt` at the next edge. An accepted strobe whose condition is false leaves `halt` at 0.
- R11: While `halt`=1, `instr_valid` has no effect: no sticky flag is set and `halt` stays 1.
- R12: While halted, a `resume` pulse clears `halt` at the next edge. When not halted, `resume` has no effect.
- R13: When `clr_we`=1, a set bit in `clr_mask` clears the matching sticky flag at the next edge (bit 0 clears unordered, bit 1 clears invalid). A set in the same cycle takes priority over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_sel | input | 5 | Condition code |
| flag_n | input | 1 | Negative result flag |
| flag_z | input | 1 | Zero result flag |
| flag_i | input | 1 | Infinity result flag |
| flag_nan | input | 1 | Not-a-number result flag |
| exc_in | input | 5 | Exception bits used by the error test |
| instr_valid | input | 1 | Conditional instruction strobe |
| resume | input | 1 | Leave debug state |
| clr_we | input | 1 | Sticky clear enable |
| clr_mask | input | 2 | Sticky bits to clear |
| cond_true | output | 1 | Evaluated condition |
| halt | output | 1 | Core held in debug state |
| unord_sticky | output | 1 | Sticky unordered-compare flag |
| inval_sticky | output | 1 | Sticky invalid-operation flag |

## Verification
The assertions check the following on every cycle. A sticky flag may rise only after a strobe accepted in run state. It may fall only after a matching clear request. `halt` may rise only after an accepted true condition and fall only after a resume. Codes that tolerate a NaN never request a sticky set. Only the bench scenarios can show that each code's truth table is correct across all flag combinations. The same applies to the error test's dependence on the sticky unordered bit and to the set-over-clear priority, which are compared against a reference model in the bench.

// File: rtl/fcond_pkg.sv
// Package: condition code encoding shared by the evaluator and its bench.
// Assumes a 5-bit selector; codes at or above CODE_COUNT are treated as unused.
package fcond_pkg;
    localparam int SEL_W      = 5;
    localparam int EXC_W      = 5;
    localparam int CODE_COUNT = 21;

    typedef enum logic [SEL_W-1:0] {
        C_EQ   = 5'd0,  C_ERR  = 5'd1,  C_GE   = 5'd2,  C_GL   = 5'd3,
        C_GLE  = 5'd4,  C_GT   = 5'd5,  C_INF  = 5'd6,  C_LE   = 5'd7,
        C_LT   = 5'd8,  C_MI   = 5'd9,  C_NE   = 5'd10, C_NGE  = 5'd11,
        C_NGL  = 5'd12, C_NGLE = 5'd13, C_NGT  = 5'd14, C_NINF = 5'd15,
        C_NLE  = 5'd16, C_NLT  = 5'd17, C_OR   = 5'd18, C_PL   = 5'd19,
        C_UN   = 5'd20
    } cond_e;
endpackage

// File: rtl/fcond_decode.sv
// Module: fcond_decode
// Purely combinational evaluation of the selected condition. It also reports
// whether the code is one of the NaN-intolerant ones. Assumes the flags are
// stable for the cycle. Unused codes give false and are not flagged intolerant.
module fcond_decode
    import fcond_pkg::*;
#(
    parameter int EXC_BITS = EXC_W
) (
    input  logic [SEL_W-1:0]    sel,
    input  logic                n,
    input  logic                z,
    input  logic                inf,
    input  logic                nan,
    input  logic                unord,
    input  logic [EXC_BITS-1:0] exc,
    output logic                result,
    output logic                nan_strict
);
    logic gt_x, ge_x, lt_x, le_x, gl_x, gle_x, err_x;

    // Raw "condition false" terms of the ordered comparisons.
    always_comb begin
        gt_x  = nan | z | n;
        ge_x  = nan | (n & ~z);
        lt_x  = nan | z | ~n;
        le_x  = nan | ~(n | z);
        gl_x  = nan | z;
        gle_x = nan;
        err_x = unord | (|exc);
    end

    // Select the result and classify the code.
    always_comb begin
        result     = 1'b0;
        nan_strict = 1'b0;
        case (sel)
            C_EQ:   result = z;
            C_NE:   result = ~z;
            C_MI:   result = n;
            C_PL:   result = ~n;
            C_OR:   result = ~nan;
            C_UN:   result = nan;
            C_ERR:  result = err_x;
            C_GT:   begin result = ~gt_x;  nan_strict = 1'b1; end
            C_GE:   begin result = ~ge_x;  nan_strict = 1'b1; end
            C_LT:   begin result = ~lt_x;  nan_strict = 1'b1; end
            C_LE:   begin result = ~le_x;  nan_strict = 1'b1; end
            C_GL:   begin result = ~gl_x;  nan_strict = 1'b1; end
            C_GLE:  begin result = ~gle_x; nan_strict = 1'b1; end
            C_NGT:  begin result = gt_x;   nan_strict = 1'b1; end
            C_NGE:  begin result = ge_x;   nan_strict = 1'b1; end
            C_NLT:  begin result = lt_x;   nan_strict = 1'b1; end
            C_NLE:  begin result = le_x;   nan_strict = 1'b1; end
            C_NGL:  begin result = gl_x;   nan_strict = 1'b1; end
            C_NGLE: begin result = gle_x;  nan_strict = 1'b1; end
            C_INF:  begin result = inf;    nan_strict = 1'b1; end
            C_NINF: begin result = ~inf;   nan_strict = 1'b1; end
            default: begin result = 1'b0;  nan_strict = 1'b0; end
        endcase
    end

    // R7: a code outside the defined range is never true
    always_comb begin
        if (sel >= SEL_W'(CODE_COUNT)) begin
            unused_false_chk: assert (!result && !nan_strict);
        end
    end
endmodule

// File: rtl/fcond_sticky.sv
// Module: fcond_sticky
// A bank of set-only sticky flags with a masked synchronous clear.
// Assumes set requests win over a clear in the same cycle.
module fcond_sticky #(
    parameter int NFLAGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] set_req,
    input  logic              clr_we,
    input  logic [NFLAGS-1:0] clr_mask,
    output logic [NFLAGS-1:0] flags
);
    for (genvar g = 0; g < NFLAGS; g++) begin : g_bit
        // Hold, set or clear one sticky bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[g] <= 1'b0;
            else if (set_req[g])
                flags[g] <= 1'b1;
            else if (clr_we && clr_mask[g])
                flags[g] <= 1'b0;
        end

        // R13: a flag only drops after a clear request for it
        sticky_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[g]) |-> $past(clr_we && clr_mask[g]));

        // R8: a flag only rises after a set request for it
        sticky_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[g]) |-> $past(set_req[g]));
    end
endmodule

// File: rtl/fcond_fsm.sv
// Module: fcond_fsm
// Run/debug state machine. Accepts a strobe only in run state. A true
// condition enters debug state, where it waits for a resume pulse.
module fcond_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic cond,
    input  logic resume,
    output logic accept,
    output logic halted
);
    typedef enum logic {ST_RUN = 1'b0, ST_DEBUG = 1'b1} st_e;
    st_e st_q;

    // Next-state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_RUN;
        else if (st_q == ST_RUN && strobe && cond)
            st_q <= ST_DEBUG;
        else if (st_q == ST_DEBUG && resume)
            st_q <= ST_RUN;
    end

    // Decode outputs from the state.
    always_comb begin
        halted = (st_q == ST_DEBUG);
        accept = strobe && (st_q == ST_RUN);
    end

    // R10: entry into debug only follows an accepted true condition
    halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(strobe && cond));

    // R12: exit from debug only follows a resume
    halt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halted) |-> $past(resume));

    // R11: strobes in debug state are not accepted
    no_accept_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !accept);
endmodule

// File: rtl/fcond_trap.sv
// Module: fcond_trap (top)
// Evaluates a floating-point condition, raises sticky unordered and invalid
// flags for NaN-intolerant codes, and halts the core into debug state on a
// true condition. Assumes the flags are valid in the cycle of instr_valid.
module fcond_trap
    import fcond_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] cond_sel,
    input  logic             flag_n,
    input  logic             flag_z,
    input  logic             flag_i,
    input  logic             flag_nan,
    input  logic [EXC_W-1:0] exc_in,
    input  logic             instr_valid,
    input  logic             resume,
    input  logic             clr_we,
    input  logic [1:0]       clr_mask,
    output logic             cond_true,
    output logic             halt,
    output logic             unord_sticky,
    output logic             inval_sticky
);
    localparam int NSTICKY = 2;

    logic               strict_code;
    logic               accepted;
    logic [NSTICKY-1:0] set_req;
    logic [NSTICKY-1:0] sticky_q;

    fcond_decode #(.EXC_BITS(EXC_W)) decode_i (
        .sel        (cond_sel),
        .n          (flag_n),
        .z          (flag_z),
        .inf        (flag_i),
        .nan        (flag_nan),
        .unord      (sticky_q[0]),
        .exc        (exc_in),
        .result     (cond_true),
        .nan_strict (strict_code)
    );

    fcond_fsm fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (instr_valid),
        .cond   (cond_true),
        .resume (resume),
        .accept (accepted),
        .halted (halt)
    );

    // Request both sticky flags when a strict code meets a NaN.
    always_comb begin
        set_req = {NSTICKY{accepted && strict_code && flag_nan}};
    end

    fcond_sticky #(.NFLAGS(NSTICKY)) sticky_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (set_req),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .flags    (sticky_q)
    );

    // Map the sticky bank to the named outputs.
    always_comb begin
        unord_sticky = sticky_q[0];
        inval_sticky = sticky_q[1];
    end

    // R9: NaN-tolerant codes never request a sticky set
    tolerant_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !strict_code) |-> (set_req == '0));

    // R11: sticky flags never rise from a strobe seen while halted
    halted_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(unord_sticky) || $rose(inval_sticky)) |-> $past(!halt && instr_valid));
endmodule

// File: tb/fcond_trap_tb_top.sv
// Bench for fcond_trap: a reference model, directed corners and seeded random stimulus.
module fcond_trap_tb_top;
    import fcond_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [SEL_W-1:0] cond_sel;
    logic             flag_n, flag_z, flag_i, flag_nan;
    logic [EXC_W-1:0] exc_in;
    logic             instr_valid, resume, clr_we;
    logic [1:0]       clr_mask;
    logic             cond_true, halt, unord_sticky, inval_sticky;

    int n_chk = 0;
    int n_bad = 0;
    logic m_halt, m_u, m_v;

    always #5 clk = ~clk;

    fcond_trap dut_i (
        .clk(clk), .rst_n(rst_n), .cond_sel(cond_sel), .flag_n(flag_n),
        .flag_z(flag_z), .flag_i(flag_i), .flag_nan(flag_nan), .exc_in(exc_in),
        .instr_valid(instr_valid), .resume(resume), .clr_we(clr_we),
        .clr_mask(clr_mask), .cond_true(cond_true), .halt(halt),
        .unord_sticky(unord_sticky), .inval_sticky(inval_sticky)
    );

    function automatic logic ref_cond(input int s, input logic n, input logic z,
                                      input logic i, input logic nan,
                                      input logic u, input logic [EXC_W-1:0] e);
        logic ordered;
        ordered = !nan;
        case (s)
            0:  return z;
            10: return !z;
            9:  return n;
            19: return !n;
            18: return ordered;
            20: return nan;
            1:  return u || (e != 0);
            5:  return ordered && !z && !n;
            2:  return ordered && !(n && !z);
            8:  return ordered && !z && n;
            7:  return ordered && (n || z);
            3:  return ordered && !z;
            4:  return ordered;
            14: return !(ordered && !z && !n);
            11: return !(ordered && !(n && !z));
            17: return !(ordered && !z && n);
            16: return !(ordered && (n || z));
            12: return !(ordered && !z);
            13: return nan;
            6:  return i;
            15: return !i;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic ref_strict(input int s);
        return (s >= 2 && s <= 8) || (s >= 11 && s <= 17);
    endfunction

    function automatic string cond_tag(input int s);
        if (s == 0 || s == 9 || s == 10 || s == 18 || s == 19 || s == 20) return "R2";
        if (s >= 2 && s <= 8 && s != 6) return "R3";
        if (s >= 11 && s <= 17 && s != 15) return "R4";
        if (s == 6 || s == 15) return "R5";
        if (s == 1) return "R6";
        return "R7";
    endfunction

    task automatic check(input string tag, input logic got, input logic exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got=%b exp=%b", tag, what, got, exp);
        end
    endtask

    // One cycle: drive at negedge, check the comb result, step the model, check state.
    task automatic step(input int s, input logic n, input logic z, input logic i,
                        input logic nan, input logic [EXC_W-1:0] e, input logic iv,
                        input logic rs, input logic cw, input logic [1:0] cm);
        logic acc, c, st, pre_halt;
        string tag;
        @(negedge clk);
        cond_sel = SEL_W'(s); flag_n = n; flag_z = z; flag_i = i; flag_nan = nan;
        exc_in = e; instr_valid = iv; resume = rs; clr_we = cw; clr_mask = cm;
        #1;
        c = ref_cond(s, n, z, i, nan, m_u, e);
        check(cond_tag(s), cond_true, c, "cond_true");
        pre_halt = m_halt;
        acc = iv && !m_halt;
        st  = acc && ref_strict(s) && nan;
        m_u = st || (m_u && !(cw && cm[0]));
        m_v = st || (m_v && !(cw && cm[1]));
        m_halt = m_halt ? !rs : (acc && c);
        @(posedge clk); #1;
        if (pre_halt) tag = iv ? "R11" : "R12";
        else if (cw) tag = "R13";
        else if (s >= CODE_COUNT) tag = "R7";
        else if (ref_strict(s)) tag = "R8";
        else tag = "R9";
        check(pre_halt ? tag : "R10", halt, m_halt, "halt");
        check(tag, unord_sticky, m_u, "unord_sticky");
        check(tag, inval_sticky, m_v, "inval_sticky");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst_n = 1'b0; cond_sel = '0; flag_n = 0; flag_z = 0; flag_i = 0;
        flag_nan = 0; exc_in = '0; instr_valid = 0; resume = 0; clr_we = 0;
        clr_mask = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", halt, 1'b0, "halt");
        check("R1", unord_sticky, 1'b0, "unord_sticky");
        check("R1", inval_sticky, 1'b0, "inval_sticky");
        @(negedge clk); rst_n = 1'b1;
        m_halt = 0; m_u = 0; m_v = 0;

        // R7: unused code with NaN and a strobe: no halt, no sticky set
        step(25, 1, 1, 1, 1, 5'h1f, 1, 0, 0, 2'b00);
        // R9: unordered test true on NaN halts but sets nothing
        step(20, 0, 0, 0, 1, '0, 1, 0, 0, 2'b00);
        // R11: strict code with NaN while halted is ignored
        step(5, 0, 0, 0, 1, '0, 1, 0, 0, 2'b00);
        // R12: resume returns to run
        step(0, 0, 0, 0, 0, '0, 0, 1, 0, 2'b00);
        // R12: resume in run has no effect
        step(0, 0, 0, 0, 0, '0, 0, 1, 0, 2'b00);
        // R8: greater-than on NaN is false, sets both stickies
        step(5, 0, 0, 0, 1, '0, 1, 0, 0, 2'b00);
        // R6: error test now true through the sticky unordered bit (no strobe)
        step(1, 0, 0, 0, 0, '0, 0, 0, 0, 2'b00);
        // R13: set wins over clear in the same cycle
        step(2, 0, 0, 0, 1, '0, 1, 0, 1, 2'b11);
        // R13: masked clear of unordered only
        step(0, 0, 0, 0, 0, '0, 0, 0, 1, 2'b01);
        step(0, 0, 0, 0, 0, '0, 0, 0, 1, 2'b10);
        // R3: less-or-equal true on zero, halts
        step(7, 0, 1, 0, 0, '0, 1, 0, 0, 2'b00);
        step(7, 0, 1, 0, 0, '0, 0, 1, 0, 2'b00);

        // Sweep every code over every flag combination without strobes.
        for (int s = 0; s < 32; s++) begin
            for (int f = 0; f < 16; f++) begin
                step(s, f[0], f[1], f[2], f[3], EXC_W'(f), 0, 0, 0, 2'b00);
            end
        end

        // Seeded random mix.
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom;
            step(int'($urandom_range(0, 31)), r[0], r[1], r[2], r[3],
                 (r[8:6] == 0) ? EXC_W'(r[13:9]) : '0,
                 r[4] | r[5], r[16:14] == 0, r[19:17] == 0, r[21:20]);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule